// File: doc/BRIEF.md
# Control-Flow Signature Watchdog

This block watches a monitored processor from the side and confirms that it moves through the basic blocks of its program only along permitted edges. The monitored processor tags each basic block with a small integer signature, and at the start of every block it writes that signature into the watchdog through a valid/data port. The watchdog never sees the processor's bus or instruction stream. It only ever sees these explicit writes. It checks each arriving signature against a successor table. The table is indexed by the previously accepted signature, which acts as the reference pointer. Each row is a bitmap whose bit n set means that signature n may follow. The check confirms that the path is allowed. It does not confirm that the branch decision that picked the path was the right one.

Every table row also holds a tag that marks a signature as an ordinary block, the first block of a procedure, or the last block of a procedure. When a procedure-entry signature arrives, the current reference pointer is saved on a small internal stack and checking resumes from the entry block. When a procedure-exit signature is accepted, the saved pointer is restored. The next signature must then be a legal successor of the call site, so return paths are checked as well.

Software fills the table while the `run` input is low. Raising `run` starts checking from a fixed entry signature. Any violation sets a sticky error flag and captures the offending signature.

Top module: `cfsig_watchdog`

## Requirements
- R1: While `run` is low, and again after every rise of `run`, the checker waits for its first signature. That first signature is accepted only if it equals parameter ENTRY_SIG (default 0). Any other value is a violation. After reset `err_flag` and `resp_valid` are 0.
- R2: A signature presented with `sig_valid` high and `run` high gets its verdict on `resp_valid`/`resp_ok` in the next cycle. One signature can be presented in every cycle. `resp_valid` is low in any cycle that does not follow such a presentation.
- R3: An ordinary signature s (tag 2'b00, or the unused code 2'b11) is accepted only if bit s of the successor bitmap in the row of the reference pointer is 1. When it is accepted, s becomes the new reference pointer.
- R4: A signature of NUM_SIG (default 32) or greater has no table row and is always a violation.
- R5: A signature tagged procedure-entry (2'b01) is accepted from any reference pointer as long as the stack is not full. The old pointer is pushed, and the entry signature becomes the reference pointer.
- R6: A signature tagged procedure-exit (2'b10) must be a legal successor of the reference pointer, and the stack must not be empty. When it is accepted, the pointer is popped, and the next signature is checked against the popped call-site signature.
- R7: Presenting a procedure-entry signature while the stack holds STACK_DEPTH (default 8) entries is a violation. Presenting a procedure-exit signature while the stack is empty is also a violation.
- R8: A violation sets `err_flag`, which stays set until `err_clear` is high. `err_sig` holds the first offending signature since the last clear. When a violation and `err_clear` arrive in the same cycle, the flag stays set and the new signature is captured.
- R9: A rejected signature leaves the reference pointer and the stack unchanged.
- R10: Table writes are taken only while `run` is low, and a write made while `run` is high has no effect. A signature presented while `run` is low produces no verdict.
- R11: Lowering `run` empties the stack and forgets the reference pointer. The table contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High: checking. Low: table loading and tracking reset |
| ld_valid | input | 1 | Table write strobe |
| ld_addr | input | SIG_W | Signature whose row is written |
| ld_succ | input | NUM_SIG | Successor bitmap, bit n allows signature n |
| ld_tag | input | 2 | Block kind: 00 ordinary, 01 procedure entry, 10 procedure exit |
| sig_valid | input | 1 | Signature write strobe from the monitored processor |
| sig | input | SIG_W | Block signature |
| err_clear | input | 1 | Clears the sticky error |
| resp_valid | output | 1 | Verdict valid, one cycle after the signature |
| resp_ok | output | 1 | Verdict: 1 means the transition was legal |
| err_flag | output | 1 | Sticky violation flag |
| err_sig | output | SIG_W | First offending signature since the last clear |

## Verification
A corrupted reference pointer shows up at the verdict of the very next signature, as a false rejection or a false acceptance. A stack that pushes or pops the wrong value stays hidden until the matching procedure exit. The failure then appears one cycle after the first signature that follows the return. The bench therefore runs nested calls and checks the signature after each return, not only the exit itself. A flag that fails to stick, or a capture that takes a later signature in place of the first, is visible on `err_flag`/`err_sig` as soon as a second violation or a clear arrives.

// File: rtl/cfsig_pkg.sv
package cfsig_pkg;

    typedef enum logic [1:0] {
        BLK_PLAIN = 2'b00,
        BLK_ENTRY = 2'b01,
        BLK_EXIT  = 2'b10,
        BLK_RSVD  = 2'b11
    } blk_kind_e;

endpackage

// File: rtl/cfsig_succ_table.sv
module cfsig_succ_table
    import cfsig_pkg::*;
#(
    parameter int SIG_W   = 8,
    parameter int NUM_SIG = 32,
    localparam int IDX_W  = $clog2(NUM_SIG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SIG_W-1:0]   wr_addr,
    input  logic [NUM_SIG-1:0] wr_succ,
    input  blk_kind_e          wr_kind,
    input  logic [IDX_W-1:0]   row_idx,
    output logic [NUM_SIG-1:0] row_succ,
    input  logic [IDX_W-1:0]   kind_idx,
    output blk_kind_e          kind_out
);

    logic [NUM_SIG-1:0] succ_d [NUM_SIG];
    logic [NUM_SIG-1:0] succ_q [NUM_SIG];
    blk_kind_e          kind_d [NUM_SIG];
    blk_kind_e          kind_q [NUM_SIG];
    logic               wr_hit;

    assign wr_hit = wr_en && (wr_addr < SIG_W'(NUM_SIG));

    always_comb begin
        for (int i = 0; i < NUM_SIG; i++) begin
            succ_d[i] = succ_q[i];
            kind_d[i] = kind_q[i];
        end
        if (wr_hit) begin
            succ_d[IDX_W'(wr_addr)] = wr_succ;
            kind_d[IDX_W'(wr_addr)] = wr_kind;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SIG; i++) begin
            if (!rst_n) begin
                succ_q[i] <= '0;
                kind_q[i] <= BLK_PLAIN;
            end else begin
                succ_q[i] <= succ_d[i];
                kind_q[i] <= kind_d[i];
            end
        end
    end

    assign row_succ = succ_q[row_idx];
    assign kind_out = kind_q[kind_idx];

endmodule

// File: rtl/cfsig_call_stack.sv
module cfsig_call_stack #(
    parameter int SIG_W = 8,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [SIG_W-1:0] push_val,
    output logic [SIG_W-1:0] top_val,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] level
);

    typedef struct packed {
        logic [CNT_W-1:0] sp;
    } stk_st_t;

    stk_st_t          st_d, st_q;
    logic [SIG_W-1:0] mem_d [DEPTH];
    logic [SIG_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_idx, top_idx;

    assign wr_idx  = PTR_W'(st_q.sp);
    assign top_idx = PTR_W'(st_q.sp - 1'b1);
    assign full    = (st_q.sp == CNT_W'(DEPTH));
    assign empty   = (st_q.sp == '0);
    assign level   = st_q.sp;
    assign top_val = mem_q[top_idx];

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (flush) begin
            st_d.sp = '0;
        end else if (push && !full) begin
            mem_d[wr_idx] = push_val;
            st_d.sp       = st_q.sp + 1'b1;
        end else if (pop && !empty) begin
            st_d.sp = st_q.sp - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end

    assert_push_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush && !full) |=> (level == $past(level) + 1'b1));

    assert_pop_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && !empty) |=> (level == $past(level) - 1'b1));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !flush) |=> (level == CNT_W'(DEPTH)) || $past(pop));

endmodule

// File: rtl/cfsig_watchdog.sv
module cfsig_watchdog
    import cfsig_pkg::*;
#(
    parameter int             SIG_W       = 8,
    parameter int             NUM_SIG     = 32,
    parameter int             STACK_DEPTH = 8,
    parameter logic [SIG_W-1:0] ENTRY_SIG = '0,
    localparam int            IDX_W       = $clog2(NUM_SIG),
    localparam int            CNT_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               ld_valid,
    input  logic [SIG_W-1:0]   ld_addr,
    input  logic [NUM_SIG-1:0] ld_succ,
    input  logic [1:0]         ld_tag,
    input  logic               sig_valid,
    input  logic [SIG_W-1:0]   sig,
    input  logic               err_clear,
    output logic               resp_valid,
    output logic               resp_ok,
    output logic               err_flag,
    output logic [SIG_W-1:0]   err_sig
);

    typedef struct packed {
        logic [SIG_W-1:0] ref_ptr;
        logic             started;
        logic             rv;
        logic             rok;
        logic             err;
        logic [SIG_W-1:0] esig;
    } wd_st_t;

    wd_st_t             st_d, st_q;
    logic [NUM_SIG-1:0] row_succ;
    blk_kind_e          in_kind;
    logic               in_range, succ_hit, take;
    logic               stk_push, stk_pop, stk_full, stk_empty;
    logic [SIG_W-1:0]   stk_top;
    logic [CNT_W-1:0]   stk_level;
    logic               legal;

    cfsig_succ_table #(.SIG_W(SIG_W), .NUM_SIG(NUM_SIG)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ld_valid && !run),
        .wr_addr  (ld_addr),
        .wr_succ  (ld_succ),
        .wr_kind  (blk_kind_e'(ld_tag)),
        .row_idx  (IDX_W'(st_q.ref_ptr)),
        .row_succ (row_succ),
        .kind_idx (IDX_W'(sig)),
        .kind_out (in_kind)
    );

    cfsig_call_stack #(.SIG_W(SIG_W), .DEPTH(STACK_DEPTH)) stack_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (!run),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_val (st_q.ref_ptr),
        .top_val  (stk_top),
        .full     (stk_full),
        .empty    (stk_empty),
        .level    (stk_level)
    );

    assign in_range = (sig < SIG_W'(NUM_SIG));
    assign succ_hit = row_succ[IDX_W'(sig)];
    assign take     = sig_valid && run;

    always_comb begin
        st_d     = st_q;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        legal    = 1'b0;
        st_d.rv  = take;
        st_d.rok = 1'b0;

        if (!run) begin
            st_d.started = 1'b0;
        end else if (take) begin
            if (!st_q.started) begin
                legal = (sig == ENTRY_SIG);
                if (legal) begin
                    st_d.started = 1'b1;
                    st_d.ref_ptr = sig;
                end
            end else if (in_range) begin
                unique case (in_kind)
                    BLK_ENTRY: begin
                        legal = !stk_full;
                        if (legal) begin
                            stk_push     = 1'b1;
                            st_d.ref_ptr = sig;
                        end
                    end
                    BLK_EXIT: begin
                        legal = succ_hit && !stk_empty;
                        if (legal) begin
                            stk_pop      = 1'b1;
                            st_d.ref_ptr = stk_top;
                        end
                    end
                    default: begin
                        legal = succ_hit;
                        if (legal) st_d.ref_ptr = sig;
                    end
                endcase
            end
            st_d.rok = legal;
        end

        if (err_clear) begin
            st_d.err  = 1'b0;
            st_d.esig = '0;
        end
        if (take && !legal && (!st_q.err || err_clear)) begin
            st_d.err  = 1'b1;
            st_d.esig = sig;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resp_valid = st_q.rv;
    assign resp_ok    = st_q.rok;
    assign err_flag   = st_q.err;
    assign err_sig    = st_q.esig;

    assert_verdict_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(sig_valid && run));

    assert_no_verdict_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !resp_valid);

    assert_reject_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ok) |-> err_flag);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clear) |=> (err_flag && $stable(err_sig)));

    assert_reject_keeps_stack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !legal) |=> $stable(stk_level));

endmodule

// File: tb/cfsig_watchdog_tb_top.sv
module cfsig_watchdog_tb_top;

    localparam int SW = 8;
    localparam int NS = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          ld_valid = 1'b0;
    logic [SW-1:0] ld_addr = '0;
    logic [NS-1:0] ld_succ = '0;
    logic [1:0]    ld_tag = 2'b00;
    logic          sig_valid = 1'b0;
    logic [SW-1:0] sig = '0;
    logic          err_clear = 1'b0;
    logic          resp_valid, resp_ok, err_flag;
    logic [SW-1:0] err_sig;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfsig_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .run(run),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_succ(ld_succ), .ld_tag(ld_tag),
        .sig_valid(sig_valid), .sig(sig), .err_clear(err_clear),
        .resp_valid(resp_valid), .resp_ok(resp_ok),
        .err_flag(err_flag), .err_sig(err_sig)
    );

    // {signature, expected verdict}, presented back to back
    localparam int NV = 15;
    localparam logic [8:0] VECS [NV] = '{
        {8'd0,  1'b1}, // R1 entry
        {8'd1,  1'b1}, // R3
        {8'd2,  1'b1},
        {8'd1,  1'b1}, // loop back
        {8'd5,  1'b1},
        {8'd3,  1'b1},
        {8'd10, 1'b1}, // R5 call, push 3
        {8'd11, 1'b1},
        {8'd20, 1'b1}, // R5 nested call, push 11
        {8'd21, 1'b1}, // R6 exit, pop to 11
        {8'd12, 1'b1}, // R6 exit, pop to 3
        {8'd4,  1'b1}, // R6 return path to 3's successor
        {8'd2,  1'b0}, // R3 not a successor of 4
        {8'd12, 1'b0}, // R7 exit with empty stack
        {8'd40, 1'b0}  // R4 out of range
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input int a, input logic [NS-1:0] m, input logic [1:0] t);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = SW'(a); ld_succ = m; ld_tag = t;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk); run = 1'b0;
        @(negedge clk); run = 1'b1;
    endtask

    task automatic send(input int s, input bit clr, input string req, input bit exp_ok);
        @(negedge clk);
        sig_valid = 1'b1; sig = SW'(s); err_clear = clr;
        @(negedge clk);
        sig_valid = 1'b0; err_clear = 1'b0;
        check({req, " valid"}, 32'(resp_valid), 32'(run));
        if (run) check({req, " verdict"}, 32'(resp_ok), 32'(exp_ok));
    endtask

    task automatic clear_err();
        @(negedge clk); err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset err", 32'(err_flag), 0);
        check("R1 reset valid", 32'(resp_valid), 0);

        load(0,  32'h0000_0002, 2'b00);
        load(1,  32'h0000_0024, 2'b00);
        load(2,  32'h0000_000A, 2'b00);
        load(3,  32'h0000_0010, 2'b00);
        load(4,  32'h0000_1000, 2'b00);
        load(5,  32'h0000_0008, 2'b00);
        load(10, 32'h0000_1800, 2'b01);
        load(11, 32'h0000_1000, 2'b00);
        load(12, 32'h0000_0000, 2'b10);
        load(20, 32'h0020_0000, 2'b01);
        load(21, 32'h0000_0000, 2'b10);

        // R10: signature while idle gives no verdict
        send(0, 1'b0, "R10 idle sig", 1'b0);

        @(negedge clk); run = 1'b1;
        for (int i = 0; i <= NV; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R2 back-to-back valid", 32'(resp_valid), 1);
                check($sformatf("R3/R4/R5/R6/R7 vec %0d", i - 1), 32'(resp_ok), 32'(VECS[i-1][0]));
            end
            if (i < NV) begin
                sig_valid = 1'b1; sig = VECS[i][8:1];
            end else begin
                sig_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R2 no verdict without sig", 32'(resp_valid), 0);
        check("R8 sticky flag", 32'(err_flag), 1);
        check("R8 first offender", 32'(err_sig), 2);
        // R9: pointer still 4 after rejects, so 12 fails only for empty stack; 4->3 still illegal
        send(3, 1'b0, "R9 pointer kept", 1'b0);
        clear_err();
        check("R8 cleared", 32'(err_flag), 0);

        // R8: violation and clear together
        send(5, 1'b1, "R8 clr+err", 1'b0);
        check("R8 clr+err flag", 32'(err_flag), 1);
        check("R8 clr+err sig", 32'(err_sig), 5);

        // R1/R11: after restart only the entry signature is accepted
        restart(); clear_err();
        send(1, 1'b0, "R1 non-entry first", 1'b0);
        check("R1 err sig", 32'(err_sig), 1);
        send(0, 1'b0, "R1 entry", 1'b1);

        // R10: table write while running is ignored
        load(0, 32'h0000_0010, 2'b00);
        restart(); clear_err();
        send(0, 1'b0, "R11 entry", 1'b1);
        send(4, 1'b0, "R10 load ignored", 1'b0);

        // R7: overflow on ninth nested entry
        restart(); clear_err();
        send(0, 1'b0, "R7 path", 1'b1);
        send(1, 1'b0, "R7 path", 1'b1);
        send(2, 1'b0, "R7 path", 1'b1);
        send(3, 1'b0, "R7 path", 1'b1);
        for (int k = 0; k < 8; k++) send(10, 1'b0, "R7 push within depth", 1'b1);
        send(10, 1'b0, "R7 push when full", 1'b0);
        check("R7 err sig", 32'(err_sig), 10);
        // R9: stack unchanged, pops back through all saved 10s then to 3
        for (int k = 0; k < 7; k++) send(12, 1'b0, "R9 pop chain", 1'b1);
        send(12, 1'b0, "R6 last pop", 1'b1);
        send(4, 1'b0, "R6 return to call site", 1'b1);

        // R6: return path checked against popped call site
        restart(); clear_err();
        send(0, 1'b0, "R6 path", 1'b1);
        send(1, 1'b0, "R6 path", 1'b1);
        send(2, 1'b0, "R6 path", 1'b1);
        send(3, 1'b0, "R6 path", 1'b1);
        send(10, 1'b0, "R5 call", 1'b1);
        send(12, 1'b0, "R6 exit", 1'b1);
        send(5, 1'b0, "R6 bad return", 1'b0);
        send(4, 1'b0, "R9 good return after reject", 1'b1);
        send(11, 1'b0, "R3 not successor", 1'b0);

        // R11: restart forgets the stack
        restart(); clear_err();
        send(0, 1'b0, "R11 entry", 1'b1);
        send(12, 1'b0, "R11 stack empty", 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule